// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a slave on a two-wire serial bus. It presents a byte-addressed memory array to a bus master. The open-drain data line is split into a sampled input `sda_i` and a pull-low enable `sda_oe_o`. Both bus lines are oversampled in the system clock domain, and start and stop conditions are recognised from their relative edges. A transaction opens with a device select byte, which is checked against a fixed type nibble and three strap inputs.

Write transactions carry a two-byte word address and then one or more data bytes. The data bytes collect in a page-sized buffer. A stop condition then triggers a self-timed write cycle, during which the buffer is committed to the array and the bus is ignored. Read transactions stream bytes from an internal address counter for as long as the master acknowledges. A write-protect input turns every write into a no-op that is still acknowledged on the bus.

Top module: `eeprom_slave`

## Requirements
- R1: After reset the slave does not pull the data line low, and it accepts a transaction at once without a busy period.
- R2: A device select byte is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:1] equal `strap_i`. On any other value the slave gives no acknowledge, and it stays silent on every later byte until the next start condition.
- R3: In a write, bit 0 of the select byte is 0. The slave acknowledges the select byte, the high word-address byte, the low word-address byte (the array uses the low ADDR_W bits of the 16-bit address) and every data byte. Each acknowledge pulls the line low during the ninth clock of its byte, and the line changes only after SCL falls.
- R4: A stop that follows at least one data byte starts an internal write cycle lasting max(WR_CYCLES, 2**PAGE_W) clocks. At the end of that cycle the array holds the new bytes.
- R5: While the write cycle runs, the slave acknowledges nothing, not even its own select byte.
- R6: Inside one write, the low PAGE_W address bits step up by one per data byte and wrap within the page, and the upper bits stay fixed. If more than one page of bytes is sent, the later bytes overwrite the earlier ones at the same offset.
- R7: When `wp_i` is high at the stop, every byte is still acknowledged, the array is left unchanged and no write cycle starts.
- R8: In a read, bit 0 of the select byte is 1. The slave shifts out array bytes MSB first, starting at the address counter. The counter steps by one per byte and wraps from the last array location to 0. Reading continues while the master acknowledges. After a not-acknowledge the slave releases the line until the next start or stop.
- R9: A read that is not preceded by a word address continues from the address that follows the last byte written or read.
- R10: A start condition that arrives before the stop discards any data bytes already buffered, so no write cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Board strap value matched against select bits [3:1] |
| wp_i | input | 1 | Write-protect, high blocks all array updates |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The bench goes after page wrap, which a design that carried into the upper address bits would get wrong: it would write the bytes after offset 127 into the next page. It also checks overlong page writes for last-write-wins, and reads that run off the top of the array, where a wrong design would return bytes from beyond the array instead of wrapping to address 0. A select byte is sent right after a stop to catch a slave that acknowledges while its write cycle is still running. Protected writes are read back to expose any slave that changes the array or starts a busy period anyway. An aborted write followed by a repeated start shows whether the buffered bytes leak into the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_WAIT
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eeprom_bus_sense.sv
module eeprom_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_lvl   = scl_sync[1];
  assign sda_lvl   = sda_sync[1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // data edges while the clock line stays high
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] woff,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] roff,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  localparam int PAGE = 2 ** PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr) vld_d = '0;
    if (we)  vld_d[woff] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (we) data_q[woff] <= wdata;
  end

  assign rdata  = data_q[roff];
  assign rvalid = vld_q[roff];
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
  parameter int LEN = 200,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  output logic         busy,
  output logic [W-1:0] tick
);
  logic         busy_d;
  logic [W-1:0] tick_d;

  always_comb begin
    busy_d = busy;
    tick_d = tick;
    if (busy) begin
      if (tick == W'(LEN - 1)) begin
        busy_d = 1'b0;
        tick_d = '0;
      end else begin
        tick_d = tick + W'(1);
      end
    end else if (go) begin
      busy_d = 1'b1;
      tick_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
    end else begin
      busy <= busy_d;
      tick <= tick_d;
    end
  end
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PAGE     = 2 ** PAGE_W;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE;
  localparam int BUSY_W   = $clog2(BUSY_LEN + 1);

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, go;
  logic [BUSY_W-1:0] tick;

  phase_t            phase_q, phase_d, nxt_q, nxt_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [6:0]        shift_q, shift_d;
  logic [6:0]        rd_q, rd_d;
  logic [7:0]        hi_q, hi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ack_q, ack_d, oe_q, oe_d, pend_q, pend_d;
  logic [7:0]        byte_w;

  logic              buf_we, buf_clr, buf_rvalid;
  logic [7:0]        buf_rdata, mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  eeprom_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_write_timer #(.LEN(BUSY_LEN), .W(BUSY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .tick(tick)
  );

  eeprom_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .woff(addr_q[PAGE_W-1:0]), .wdata(byte_w),
    .roff(tick[PAGE_W-1:0]), .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  // commit: one page offset per clock during the first PAGE ticks
  assign mem_we    = busy & (tick < BUSY_W'(PAGE)) & buf_rvalid;
  assign mem_waddr = {addr_q[ADDR_W-1:PAGE_W], tick[PAGE_W-1:0]};

  eeprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(buf_rdata),
    .raddr(addr_q), .rdata(mem_rdata)
  );

  assign byte_w = {shift_q, sda_lvl};

  always_comb begin
    phase_d  = phase_q;
    nxt_d    = nxt_q;
    bitcnt_d = bitcnt_q;
    shift_d  = shift_q;
    rd_d     = rd_q;
    hi_d     = hi_q;
    addr_d   = addr_q;
    ack_d    = ack_q;
    oe_d     = oe_q;
    pend_d   = pend_q;
    buf_we   = 1'b0;
    buf_clr  = 1'b0;
    go       = 1'b0;
    if (busy) begin
      phase_d  = PH_IDLE;
      oe_d     = 1'b0;
      bitcnt_d = '0;
    end else if (start_det) begin
      phase_d  = PH_DEV;
      bitcnt_d = '0;
      oe_d     = 1'b0;
      pend_d   = 1'b0;
      buf_clr  = 1'b1;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
      pend_d  = 1'b0;
      go      = pend_q & ~wp_i;
    end else if (scl_rise) begin
      if (bitcnt_q != 4'd9) bitcnt_d = bitcnt_q + 4'd1;
      case (phase_q)
        PH_DEV, PH_AHI, PH_ALO, PH_WDAT: begin
          if (bitcnt_q < 4'd8) shift_d = byte_w[6:0];
          if (bitcnt_q == 4'd7) begin
            ack_d = 1'b1;
            case (phase_q)
              PH_DEV: begin
                if (byte_w[7:4] == DEV_TYPE && byte_w[3:1] == strap_i) begin
                  nxt_d = byte_w[0] ? PH_RDAT : PH_AHI;
                end else begin
                  ack_d   = 1'b0;
                  phase_d = PH_WAIT;
                end
              end
              PH_AHI: begin
                hi_d  = byte_w;
                nxt_d = PH_ALO;
              end
              PH_ALO: begin
                addr_d = ADDR_W'({hi_q, byte_w});
                nxt_d  = PH_WDAT;
              end
              default: begin
                buf_we = 1'b1;
                pend_d = 1'b1;
                addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                nxt_d  = PH_WDAT;
              end
            endcase
          end
        end
        PH_RDAT: begin
          if (bitcnt_q == 4'd8) nxt_d = sda_lvl ? PH_WAIT : PH_RDAT;
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      if (phase_q != PH_IDLE && phase_q != PH_WAIT) begin
        if (bitcnt_q == 4'd9) begin
          bitcnt_d = '0;
          phase_d  = nxt_q;
          oe_d     = 1'b0;
          if (nxt_q == PH_RDAT) begin
            rd_d   = mem_rdata[6:0];
            oe_d   = ~mem_rdata[7];
            addr_d = addr_q + ADDR_W'(1);
          end
        end else if (bitcnt_q == 4'd8) begin
          oe_d = (phase_q == PH_RDAT) ? 1'b0 : ack_q;
        end else if (phase_q == PH_RDAT && bitcnt_q != 4'd0) begin
          oe_d = ~rd_q[6];
          rd_d = {rd_q[5:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      nxt_q    <= PH_IDLE;
      bitcnt_q <= '0;
      shift_q  <= '0;
      rd_q     <= '0;
      hi_q     <= '0;
      addr_q   <= '0;
      ack_q    <= 1'b0;
      oe_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      nxt_q    <= nxt_d;
      bitcnt_q <= bitcnt_d;
      shift_q  <= shift_d;
      rd_q     <= rd_d;
      hi_q     <= hi_d;
      addr_q   <= addr_d;
      ack_q    <= ack_d;
      oe_q     <= oe_d;
      pend_q   <= pend_d;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 200
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sda_oe,
  input logic                     busy,
  input logic                     scl_fall,
  input logic                     stop_det,
  input logic                     wp,
  input logic                     mem_we,
  input logic [ADDR_W-PAGE_W-1:0] page_hi
);
  localparam int PAGE     = 2 ** PAGE_W;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE;

  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  assert_drive_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == 32'(BUSY_LEN));

  assert_silent_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_page_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(page_hi));

  assert_protect_no_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));
endmodule

bind eeprom_slave eeprom_slave_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy),
  .scl_fall(scl_fall), .stop_det(stop_det), .wp(wp_i),
  .mem_we(mem_we), .page_hi(addr_q[ADDR_W-1:PAGE_W])
);

// File: tb/tb_eeprom_slave.sv
module tb_eeprom_slave;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 7;
  localparam int WRC    = 200;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int PMASK  = 2 ** PAGE_W - 1;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n, m_scl, m_sda, wp;
  logic sda_oe, sda_line;
  int   n_chk = 0, n_bad = 0;
  logic [7:0] model [DEPTH];
  bit         known [DEPTH];
  int         cur_addr = 0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  function automatic int page_addr(input int base, input int i);
    return (base & ~PMASK) | ((base + i) & PMASK);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wait_clk(3);
    m_scl = 1'b1; wait_clk(6);
    m_sda = 1'b0; wait_clk(6);
    m_scl = 1'b0; wait_clk(3);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wait_clk(3);
    m_scl = 1'b1; wait_clk(6);
    m_sda = 1'b1; wait_clk(6);
  endtask

  task automatic bus_bit(input bit b, output bit s);
    m_sda = b;    wait_clk(3);
    m_scl = 1'b1; wait_clk(3);
    s = sda_line; wait_clk(3);
    m_scl = 1'b0; wait_clk(3);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit s;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic send_addr(input int a, input string tag);
    bit ack;
    send_byte(8'(a >> 8), ack); check(ack, {tag, " addr-hi ack"}, ack, 1);
    send_byte(8'(a), ack);      check(ack, {tag, " addr-lo ack"}, ack, 1);
  endtask

  task automatic do_write(input int a, input int n, input bit prot, input bit poll, input string tag);
    bit ack;
    logic [7:0] d;
    wp = prot;
    bus_start;
    send_byte(DEVW, ack); check(ack, {tag, " R3 select ack"}, ack, 1);
    send_addr(a, {tag, " R3"});
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); check(ack, {tag, " R3 data ack"}, ack, 1);
      if (!prot) begin
        model[page_addr(a, i)] = d;
        known[page_addr(a, i)] = 1'b1;
      end
    end
    bus_stop;
    cur_addr = page_addr(a, n);
    if (poll) begin
      bus_start;
      send_byte(DEVW, ack); check(!ack, "R5 select during write cycle", ack, 0);
      bus_stop;
    end
    if (!prot) wait_clk(WRC + 30);
    wp = 1'b0;
  endtask

  task automatic do_read(input int a, input int n, input bit cur, input string tag);
    bit ack;
    logic [7:0] d;
    if (!cur) begin
      bus_start;
      send_byte(DEVW, ack); check(ack, {tag, " select ack"}, ack, 1);
      send_addr(a, tag);
      cur_addr = a;
    end
    bus_start;
    send_byte(DEVR, ack); check(ack, {tag, " R8 read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      if (known[cur_addr]) check(d === model[cur_addr], tag, int'(d), int'(model[cur_addr]));
      cur_addr = (cur_addr + 1) % DEPTH;
    end
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; rst_n = 1'b0;
    void'($urandom(32'd20240611));
    wait_clk(5);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_clk(2);
      check(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);
    end

    // R2: wrong strap and wrong type nibble, then silence on the next byte
    bus_start;
    send_byte({4'b1010, ~STRAP, 1'b0}, ack); check(!ack, "R2 wrong strap", ack, 0);
    send_byte(8'h00, ack);                   check(!ack, "R2 silent after mismatch", ack, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1011, STRAP, 1'b0}, ack);  check(!ack, "R2 wrong type nibble", ack, 0);
    bus_stop;
    // R1: first transaction straight after reset is accepted
    bus_start;
    send_byte(DEVW, ack); check(ack, "R1 immediate accept", ack, 1);
    bus_stop;

    // R4 R5: byte write with polling, then read back
    do_write(12'h012, 1, 1'b0, 1'b1, "R4");
    do_read(12'h012, 1, 1'b0, "R4 byte write readback");

    // R6: page wrap from offset 120
    do_write(12'h078, 16, 1'b0, 1'b0, "R6");
    do_read(12'h078, 8, 1'b0, "R6 wrap upper part");
    do_read(12'h000, 8, 1'b0, "R6 wrap lower part");
    check(!known[12'h080], "R6 next page untouched", known[12'h080], 0);

    // R6: overlong page write, last bytes win
    do_write(12'h080, 130, 1'b0, 1'b0, "R6 overlong");
    do_read(12'h080, 128, 1'b0, "R6 overlong readback");

    // R7: protected write, no busy period, array unchanged
    do_write(12'h012, 4, 1'b1, 1'b0, "R7");
    bus_start;
    send_byte(DEVW, ack); check(ack, "R7 no write cycle after protected stop", ack, 1);
    bus_stop;
    do_read(12'h012, 4, 1'b0, "R7 protected readback");

    // R8: read wraps past top of array; R9 continues from counter
    do_write(12'h1FC, 4, 1'b0, 1'b0, "R8");
    do_read(12'h1FE, 4, 1'b0, "R8 top wrap");
    do_read(0, 3, 1'b1, "R9 current address read");

    // R10: repeated start aborts buffered data
    d = model[12'h012];
    bus_start;
    send_byte(DEVW, ack); check(ack, "R10 select ack", ack, 1);
    send_addr(12'h012, "R10");
    send_byte(~d, ack);   check(ack, "R10 data ack", ack, 1);
    bus_start;
    send_byte(DEVW, ack); check(ack, "R10 no busy after repeated start", ack, 1);
    send_addr(12'h012, "R10");
    bus_start;
    send_byte(DEVR, ack); check(ack, "R10 read select", ack, 1);
    recv_byte(1'b0, d);   check(d === model[12'h012], "R10 data discarded", d, model[12'h012]);
    bus_stop;
    bus_start;
    send_byte(DEVW, ack); check(ack, "R10 no write cycle followed", ack, 1);
    bus_stop;
    cur_addr = 12'h013;

    // random writes and reads, checked against the model
    for (int k = 0; k < 10; k++) begin
      int a, n;
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 20);
      do_write(a, n, 1'b0, 1'b0, "R6 random");
      do_read(int'($urandom % DEPTH), 1 + int'($urandom % 24), 1'b0, "R8 random read");
      do_read(0, 2, 1'b1, "R9 random current read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule